// File: doc/BRIEF.md
# Burst-Usage Monitor and Checker

This is a passive observer for the address and control phase of a single-manager AHB-Lite bus. It drives nothing back onto the bus. It looks at each beat that the bus accepts, meaning a rising clock edge with HREADY high. It decides whether that beat opens a multi-beat burst, continues one, or is an isolated one-beat (SINGLE) access.

From this it derives three outputs:
- a registered prefetch hint for a downstream memory controller;
- a protocol-error pulse when a continuation or wait beat (SEQ or BUSY) shows up with no multi-beat burst open;
- an efficiency-warning pulse when a run of independent SINGLE accesses walks through consecutive addresses. Such block movement ought to have been issued as one burst.

Consecutive SINGLEs are never merged into a burst, even when their addresses step. A run is counted only for the warning. The run length that raises the warning is a parameter.

Top module: `burst_usage_mon`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, prefetch_hint_o, proto_err_o and seq_warn_o are all 0.
- R2: An accepted beat with htrans_i = 2'b11 (SEQ) while no multi-beat burst is open gives a one-cycle proto_err_o pulse. This includes a SEQ that follows a SINGLE (hburst_i = 3'b000). A burst is open after an accepted NONSEQ (htrans_i = 2'b10) with hburst_i other than 3'b000, and is closed by an accepted IDLE (2'b00) or an accepted SINGLE NONSEQ. A SEQ inside an open burst is not an error.
- R3: A beat counts only on a rising edge with hready_i high. While hready_i is low, no output changes state and no pulse is raised.
- R4: After an accepted NONSEQ with hburst_i not 3'b000, prefetch_hint_o is 1. After an accepted SINGLE NONSEQ or an accepted IDLE, it is 0. It holds its value across accepted SEQ and BUSY (2'b01) beats.
- R5: Back-to-back SINGLEs stay independent, even when their addresses step: prefetch_hint_o stays 0 through them, and a SEQ after the last one is still a protocol error.
- R6: A stepping SINGLE has the same hsize_i and hwrite_i as the previous SINGLE, and an haddr_i equal to that SINGLE's address plus (1 << hsize_i). When a run of RUN_THRESH consecutive SINGLEs (default 4, counting the first) has each later one stepping, seq_warn_o pulses once. Further stepping SINGLEs in the same run raise no further warning.
- R7: The run restarts at length one on a non-stepping address, or on a change of hsize_i or hwrite_i. An accepted multi-beat NONSEQ, SEQ or BUSY beat clears the run entirely.
- R8: Accepted IDLE beats between SINGLEs leave the run unchanged.
- R9: An accepted BUSY beat with no multi-beat burst open gives a one-cycle proto_err_o pulse. A BUSY inside an open burst does not.
- R10: proto_err_o and seq_warn_o are registered. Each is high for exactly the one cycle that follows the rising edge which accepted the offending beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| htrans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hburst_i | input | 3 | Declared burst type; 000 is SINGLE |
| haddr_i | input | ADDR_W | Address of the beat |
| hsize_i | input | 3 | Log2 of the transfer size in bytes |
| hwrite_i | input | 1 | Write when 1 |
| hready_i | input | 1 | Beat accepted on an edge where this is 1 |
| prefetch_hint_o | output | 1 | Registered hint: sequential block expected |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| seq_warn_o | output | 1 | One-cycle pulse for a SINGLE run that should have been a burst |

## Verification
The hardest case to reach from the ports is a stepping run that is almost, but not quite, broken. Examples are IDLE gaps, a wait state with hready_i low on the next SINGLE, or a size or direction change on exactly the step that would reach the threshold. The stimulus builds runs of exact length around RUN_THRESH. It then inserts each kind of interruption at the position that decides whether the warning fires. It also runs a long run, to confirm that the warning appears only once. Error sequences place SEQ and BUSY beats after SINGLEs, after IDLE and inside real bursts, including a SEQ held under a wait state that is replaced before it is accepted.

// File: rtl/burst_mon_pkg.sv
package burst_mon_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [2:0] BURST_ONE = 3'b000;

  // one-hot view of an accepted beat; all zero when hready is low
  typedef struct packed {
    logic idle;
    logic busy;
    logic nseq_one;
    logic nseq_multi;
    logic seq;
  } beat_t;
endpackage

// File: rtl/burst_beat_classify.sv
module burst_beat_classify
  import burst_mon_pkg::*;
(
  input  logic [1:0] htrans_i,
  input  logic [2:0] hburst_i,
  input  logic       hready_i,
  output beat_t      beat_o
);
  trans_e tr;
  logic   single;

  always_comb begin
    tr     = trans_e'(htrans_i);
    single = (hburst_i == BURST_ONE);
    beat_o = '0;
    if (hready_i) begin
      unique case (tr)
        TR_IDLE: beat_o.idle       = 1'b1;
        TR_BUSY: beat_o.busy       = 1'b1;
        TR_NSEQ: begin
          beat_o.nseq_one   = single;
          beat_o.nseq_multi = !single;
        end
        TR_SEQ:  beat_o.seq        = 1'b1;
        default: beat_o            = '0;
      endcase
    end
  end
endmodule

// File: rtl/burst_proto_track.sv
module burst_proto_track
  import burst_mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output logic  err_o,
  output logic  hint_o
);
  logic open_q, open_d;
  logic err_d, hint_d;

  always_comb begin
    open_d = open_q;
    hint_d = hint_o;
    err_d  = 1'b0;
    if (beat_i.nseq_multi) begin
      open_d = 1'b1;
      hint_d = 1'b1;
    end else if (beat_i.nseq_one || beat_i.idle) begin
      open_d = 1'b0;
      hint_d = 1'b0;
    end else if (beat_i.seq || beat_i.busy) begin
      err_d  = !open_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      hint_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      open_q <= open_d;
      hint_o <= hint_d;
      err_o  <= err_d;
    end
  end
endmodule

// File: rtl/burst_run_detect.sv
module burst_run_detect
  import burst_mon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned RUN_THRESH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  beat_t             beat_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [2:0]        hsize_i,
  input  logic              hwrite_i,
  output logic              warn_o
);
  localparam int unsigned CNT_W = $clog2(RUN_THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_THRESH);
  localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(RUN_THRESH - 1);

  logic [ADDR_W-1:0] prev_addr_q;
  logic [2:0]        prev_size_q;
  logic              prev_wr_q;
  logic              have_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              have_prev_d, warn_d;
  logic [ADDR_W-1:0] step;
  logic              stepping;

  always_comb begin
    step     = {{(ADDR_W-1){1'b0}}, 1'b1} << hsize_i;
    stepping = have_prev_q && (hsize_i == prev_size_q) && (hwrite_i == prev_wr_q)
               && (haddr_i == prev_addr_q + step);
  end

  always_comb begin
    cnt_d       = cnt_q;
    have_prev_d = have_prev_q;
    warn_d      = 1'b0;
    if (beat_i.nseq_one) begin
      have_prev_d = 1'b1;
      if (stepping) begin
        warn_d = (cnt_q == CNT_PRE);
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = CNT_W'(1);
      end
    end else if (beat_i.nseq_multi || beat_i.seq || beat_i.busy) begin
      cnt_d       = '0;
      have_prev_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      have_prev_q <= 1'b0;
      prev_addr_q <= '0;
      prev_size_q <= '0;
      prev_wr_q   <= 1'b0;
      warn_o      <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      have_prev_q <= have_prev_d;
      warn_o      <= warn_d;
      if (beat_i.nseq_one) begin
        prev_addr_q <= haddr_i;
        prev_size_q <= hsize_i;
        prev_wr_q   <= hwrite_i;
      end
    end
  end
endmodule

// File: rtl/burst_usage_mon.sv
module burst_usage_mon
  import burst_mon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned RUN_THRESH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        htrans_i,
  input  logic [2:0]        hburst_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [2:0]        hsize_i,
  input  logic              hwrite_i,
  input  logic              hready_i,
  output logic              prefetch_hint_o,
  output logic              proto_err_o,
  output logic              seq_warn_o
);
  beat_t beat;

  burst_beat_classify u_cls (
    .htrans_i (htrans_i),
    .hburst_i (hburst_i),
    .hready_i (hready_i),
    .beat_o   (beat)
  );

  burst_proto_track u_proto (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat),
    .err_o  (proto_err_o),
    .hint_o (prefetch_hint_o)
  );

  burst_run_detect #(
    .ADDR_W     (ADDR_W),
    .RUN_THRESH (RUN_THRESH)
  ) u_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .beat_i   (beat),
    .haddr_i  (haddr_i),
    .hsize_i  (hsize_i),
    .hwrite_i (hwrite_i),
    .warn_o   (seq_warn_o)
  );
endmodule

// File: rtl/burst_usage_mon_chk.sv
module burst_usage_mon_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        htrans_i,
  input logic [2:0]        hburst_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic              hready_i,
  input logic              prefetch_hint_o,
  input logic              proto_err_o,
  input logic              seq_warn_o
);
  logic acc_one, acc_multi, acc_seq, acc_quiet;
  assign acc_one   = hready_i && htrans_i == 2'b10 && hburst_i == 3'b000;
  assign acc_multi = hready_i && htrans_i == 2'b10 && hburst_i != 3'b000;
  assign acc_seq   = hready_i && htrans_i == 2'b11;
  assign acc_quiet = hready_i && (htrans_i == 2'b10 || htrans_i == 2'b00);

  // R4
  hint_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_one |=> !prefetch_hint_o);
  // R4
  hint_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_multi |=> prefetch_hint_o);
  // R3
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> (!proto_err_o && !seq_warn_o));
  // R2
  no_err_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_quiet |=> !proto_err_o);
  // R2
  seq_after_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_one) && acc_seq) |=> proto_err_o);
  // R2
  seq_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_multi) && acc_seq) |=> !proto_err_o);
  // R6
  warn_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_warn_o |-> $past(acc_one));
  // R10
  warn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_warn_o |=> !seq_warn_o);
endmodule

bind burst_usage_mon burst_usage_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .htrans_i        (htrans_i),
  .hburst_i        (hburst_i),
  .haddr_i         (haddr_i),
  .hready_i        (hready_i),
  .prefetch_hint_o (prefetch_hint_o),
  .proto_err_o     (proto_err_o),
  .seq_warn_o      (seq_warn_o)
);

// File: tb/tb_burst_usage_mon.sv
module tb_burst_usage_mon;
  localparam int CLK_PERIOD = 10;
  localparam int TH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hburst = 3'b000;
  logic [31:0] haddr = '0;
  logic [2:0]  hsize = 3'd2;
  logic        hwrite = 1'b0;
  logic        hready = 1'b1;
  logic hint, err, warn;

  int checks = 0, errors = 0;
  int seen_warn = 0, seen_err = 0;
  string tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_usage_mon #(.ADDR_W(32), .RUN_THRESH(TH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .htrans_i(htrans), .hburst_i(hburst),
    .haddr_i(haddr), .hsize_i(hsize), .hwrite_i(hwrite), .hready_i(hready),
    .prefetch_hint_o(hint), .proto_err_o(err), .seq_warn_o(warn));

  // behavioural reference
  bit m_hint, m_err, m_warn, m_open, m_have;
  int m_cnt;
  logic [31:0] m_addr;
  int m_size;
  bit m_wr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hint = 0; m_err = 0; m_warn = 0; m_open = 0; m_have = 0; m_cnt = 0;
    end else begin
      m_err = 0; m_warn = 0;
      if (hready) begin
        if (htrans == 2'b00) begin
          m_open = 0; m_hint = 0;
        end else if (htrans == 2'b01 || htrans == 2'b11) begin
          if (!m_open) m_err = 1;
          m_cnt = 0; m_have = 0;
        end else if (hburst != 3'b000) begin
          m_open = 1; m_hint = 1; m_cnt = 0; m_have = 0;
        end else begin
          m_open = 0; m_hint = 0;
          if (m_have && int'(hsize) == m_size && hwrite == m_wr &&
              haddr == m_addr + (32'd1 << hsize)) begin
            if (m_cnt == TH - 1) m_warn = 1;
            if (m_cnt < TH) m_cnt++;
          end else m_cnt = 1;
          m_have = 1; m_addr = haddr; m_size = int'(hsize); m_wr = hwrite;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "prefetch_hint_o", int'(hint), int'(m_hint));
      chk(tag, "proto_err_o", int'(err), int'(m_err));
      chk(tag, "seq_warn_o", int'(warn), int'(m_warn));
      if (warn) seen_warn++;
      if (err) seen_err++;
    end
  end

  task automatic beat(logic [1:0] t, logic [2:0] b, logic [31:0] a,
                      logic [2:0] s = 3'd2, logic w = 1'b0, logic r = 1'b1);
    htrans = t; hburst = b; haddr = a; hsize = s; hwrite = w; hready = r;
    @(negedge clk);
  endtask

  task automatic single(logic [31:0] a, logic [2:0] s = 3'd2, logic w = 1'b0);
    beat(2'b10, 3'b000, a, s, w);
  endtask

  task automatic idle();
    beat(2'b00, 3'b000, 32'h0);
  endtask

  task automatic close_scen(string req, int exp_w, int exp_e);
    idle(); idle();
    #1;
    chk(req, "warning pulses", seen_warn, exp_w);
    chk(req, "error pulses", seen_err, exp_e);
    seen_warn = 0; seen_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", "hint in reset", int'(hint), 0);
    chk("R1", "err in reset", int'(err), 0);
    chk("R1", "warn in reset", int'(warn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({hint, err, warn}), 0);

    tag = "R6";
    for (int i = 0; i < 4; i++) single(32'h100 + 4*i);
    close_scen("R6", 1, 0);

    tag = "R6";
    for (int i = 0; i < 8; i++) single(32'h200 + 4*i);
    close_scen("R6", 1, 0);

    tag = "R8";
    for (int i = 0; i < 4; i++) begin single(32'h300 + 2*i, 3'd1); idle(); idle(); end
    close_scen("R8", 1, 0);

    tag = "R3";
    single(32'h400); single(32'h404); single(32'h408);
    beat(2'b10, 3'b000, 32'h40C, 3'd2, 1'b0, 1'b0);
    beat(2'b10, 3'b000, 32'h40C, 3'd2, 1'b0, 1'b0);
    chk("R3", "no warn while stalled", int'(warn), 0);
    single(32'h40C);
    close_scen("R3", 1, 0);

    tag = "R7";
    single(32'h500); single(32'h504); single(32'h508); single(32'h510);
    single(32'h514); single(32'h518);
    close_scen("R7", 0, 0);

    tag = "R7";
    single(32'h600); single(32'h604); single(32'h608); single(32'h60A, 3'd1);
    single(32'h60C, 3'd1); single(32'h60E, 3'd1);
    close_scen("R7", 0, 0);

    tag = "R7";
    single(32'h700); single(32'h704); single(32'h708); single(32'h70C, 3'd2, 1'b1);
    close_scen("R7", 0, 0);

    tag = "R7";
    single(32'h800); single(32'h804);
    beat(2'b10, 3'b011, 32'h900); beat(2'b11, 3'b011, 32'h904);
    single(32'h808); single(32'h80C);
    close_scen("R7", 0, 0);

    tag = "R4";
    beat(2'b10, 3'b011, 32'hA00);
    chk("R4", "hint after burst start", int'(hint), 1);
    beat(2'b11, 3'b011, 32'hA04);
    beat(2'b01, 3'b011, 32'hA08);
    chk("R4", "hint held over SEQ/BUSY", int'(hint), 1);
    beat(2'b11, 3'b011, 32'hA08);
    beat(2'b11, 3'b011, 32'hA0C);
    single(32'hB00);
    chk("R4", "hint after SINGLE", int'(hint), 0);
    close_scen("R9", 0, 0);

    tag = "R2";
    single(32'hC00);
    beat(2'b11, 3'b000, 32'hC04);
    chk("R10", "err pulse one cycle after SEQ", int'(err), 1);
    idle();
    chk("R10", "err pulse ends", int'(err), 0);
    close_scen("R2", 0, 1);

    tag = "R5";
    for (int i = 0; i < 4; i++) begin
      single(32'hD00 + 4*i);
      chk("R5", "hint low in SINGLE run", int'(hint), 0);
    end
    beat(2'b11, 3'b000, 32'hD10);
    close_scen("R5", 1, 1);

    tag = "R9";
    beat(2'b01, 3'b000, 32'hE00);
    close_scen("R9", 0, 1);

    tag = "R3";
    single(32'hF00);
    beat(2'b11, 3'b000, 32'hF04, 3'd2, 1'b0, 1'b0);
    beat(2'b11, 3'b000, 32'hF04, 3'd2, 1'b0, 1'b0);
    close_scen("R3", 0, 0);

    tag = "R2";
    beat(2'b11, 3'b001, 32'h1000);
    close_scen("R2", 0, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule